// File: doc/BRIEF.md
# Clock-Enabled Bus Output Sequencer

This block drives a processor's bus-ownership and transfer-active output pins when the external bus runs slower than the core clock. A clock-enable input marks which core clock rising edges count as bus clock edges. The ownership outputs normally change only on those qualified edges. The status outputs, the reset-request output and the interrupt sampling logic run on every core edge.

Each bus output is an active-low channel with its own output-enable, which models a three-state pin. A channel drives only while the bus is granted. If the grant is withdrawn while a channel is asserted, the channel pulls its pin to the inactive level for exactly one core clock and then releases it. This happens even when no bus clock edge falls in that window, so an asserted pin never floats straight from low. A channel that is inactive when the grant goes away simply releases on the next bus clock edge. Arbitration policy, address and data paths and transfer termination are handled elsewhere.

Top module: `bus_out_seq`

## Requirements
- R1: While the synchronous active-high reset is sampled high, every channel output is high and every output-enable is low. The status output is zero, the reset-request output is high, the sampled interrupt level is zero and the pending output is high.
- R2: A bus clock edge is a core rising edge with `clk_en` high. A released channel starts driving on the first bus clock edge with `grant` high. On that edge its output-enable goes to 1 and its output to the inverse of its request bit.
- R3: While a channel is driving and granted, its output takes the inverse of its request bit only on bus clock edges and holds its value on other core edges.
- R4: If `grant` is low on a core edge while a driving channel's output is low, then after that edge the output is high and its output-enable stays 1. This happens whatever the level of `clk_en`.
- R5: The active negation of R4 lasts exactly one core clock. On the next core edge the output-enable goes to 0 with the output high, whatever `clk_en` and `grant` are.
- R6: If `grant` is low while a driving channel's output is high, the channel keeps its output-enable at 1 until the next bus clock edge, and then releases it to 0.
- R7: After a release, a returning `grant` does not enable the channel on core edges where `clk_en` is low. Driving resumes on the next bus clock edge.
- R8: `stat_o` is the value of `stat_in` registered on every core edge, independent of `clk_en`.
- R9: `rst_out_n` is the inverse of `rst_out_req` registered on every core edge, independent of `clk_en`.
- R10: The interrupt inputs are active-low. On every core edge `irq_lvl_o` is loaded with the bitwise inverse of `irq_lvl_n`. On the same edge `irq_pend_n` is loaded with 0 when that level is strictly greater than `irq_mask`, and with 1 otherwise.
- R11: Channels sequence independently. Bit i of `chan_req`, `chan_n` and `chan_oe` belong to channel i: bit 0 is bus-busy and bit 1 is transfer-in-progress. One channel can be negating or releasing while another is still driving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Bus clock qualifier |
| grant | input | 1 | Bus ownership granted to this processor |
| chan_req | input | NUM_CH | Per-channel assert request from the bus controller |
| stat_in | input | STAT_W | Processor status to present |
| rst_out_req | input | 1 | Request to assert the reset output |
| irq_lvl_n | input | LVL_W | Active-low encoded interrupt level |
| irq_mask | input | LVL_W | Current interrupt mask level |
| chan_n | output | NUM_CH | Active-low channel pin values |
| chan_oe | output | NUM_CH | Per-channel pin output-enable |
| stat_o | output | STAT_W | Registered processor status |
| rst_out_n | output | 1 | Active-low reset output |
| irq_lvl_o | output | LVL_W | Sampled interrupt level |
| irq_pend_n | output | 1 | Active-low interrupt-pending output |

## Verification
The bench builds the block with its defaults: two channels, a three-bit status word and a three-bit interrupt level. With two channels it can take the grant away while one channel is asserted and the other is idle. That exposes the negate path and the wait-for-bus-edge release path side by side, in the same cycles. The three-bit level and mask widths make the strict-greater comparison reachable at, above and below the mask.

// File: rtl/bus_out_seq_pkg.sv
package bus_out_seq_pkg;

    typedef enum logic [1:0] {
        CH_RELEASED = 2'd0,
        CH_DRIVE    = 2'd1,
        CH_NEGATE   = 2'd2
    } ch_state_e;

    typedef struct packed {
        ch_state_e st;
        logic      pin_n;
    } ch_regs_t;

endpackage

// File: rtl/bus_out_chan.sv
module bus_out_chan
    import bus_out_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clk_en,
    input  logic grant,
    input  logic req,
    output logic pin_n,
    output logic pin_oe
);

    ch_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            CH_RELEASED: begin
                r_d.pin_n = 1'b1;
                if (clk_en && grant) begin
                    r_d.st    = CH_DRIVE;
                    r_d.pin_n = ~req;
                end
            end
            CH_DRIVE: begin
                if (!grant) begin
                    if (!r_q.pin_n) begin
                        r_d.st    = CH_NEGATE;
                        r_d.pin_n = 1'b1;
                    end else if (clk_en) begin
                        r_d.st    = CH_RELEASED;
                        r_d.pin_n = 1'b1;
                    end
                end else if (clk_en) begin
                    r_d.pin_n = ~req;
                end
            end
            CH_NEGATE: begin
                r_d.st    = CH_RELEASED;
                r_d.pin_n = 1'b1;
            end
            default: begin
                r_d.st    = CH_RELEASED;
                r_d.pin_n = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st    <= CH_RELEASED;
            r_q.pin_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign pin_n  = r_q.pin_n;
    assign pin_oe = (r_q.st != CH_RELEASED);

    assert_hold_between_edges_R3: assert property (@(posedge clk) disable iff (rst)
        (pin_oe && grant && !clk_en) |=> $stable(pin_n));

    assert_negate_on_loss_R4: assert property (@(posedge clk) disable iff (rst)
        (pin_oe && !pin_n && !grant) |=> (pin_oe && pin_n));

    assert_negate_one_clock_R5: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == CH_NEGATE) |=> !pin_oe);

    assert_idle_loss_waits_R6: assert property (@(posedge clk) disable iff (rst)
        (pin_oe && pin_n && !grant && !clk_en && r_q.st == CH_DRIVE) |=> pin_oe);

    assert_no_early_regrant_R7: assert property (@(posedge clk) disable iff (rst)
        (!pin_oe && !clk_en) |=> !pin_oe);

    assert_released_high_R1: assert property (@(posedge clk) disable iff (rst)
        !pin_oe |-> pin_n);

endmodule

// File: rtl/bus_out_status.sv
module bus_out_status #(
    parameter int STAT_W = 3,
    parameter int LVL_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] stat_in,
    input  logic              rst_out_req,
    input  logic [LVL_W-1:0]  irq_lvl_n,
    input  logic [LVL_W-1:0]  irq_mask,
    output logic [STAT_W-1:0] stat_o,
    output logic              rst_out_n,
    output logic [LVL_W-1:0]  irq_lvl_o,
    output logic              irq_pend_n
);

    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic              rsto_n;
        logic [LVL_W-1:0]  lvl;
        logic              pend_n;
    } st_regs_t;

    st_regs_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.stat   = stat_in;
        s_d.rsto_n = ~rst_out_req;
        s_d.lvl    = ~irq_lvl_n;
        s_d.pend_n = !((~irq_lvl_n) > irq_mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.stat   <= '0;
            s_q.rsto_n <= 1'b1;
            s_q.lvl    <= '0;
            s_q.pend_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign stat_o     = s_q.stat;
    assign rst_out_n  = s_q.rsto_n;
    assign irq_lvl_o  = s_q.lvl;
    assign irq_pend_n = s_q.pend_n;

    assert_stat_every_edge_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (stat_o == $past(stat_in)));

    assert_rsto_every_edge_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (rst_out_n == !$past(rst_out_req)));

    assert_pend_vs_level_R10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_pend_n == !(irq_lvl_o > $past(irq_mask))));

endmodule

// File: rtl/bus_out_seq.sv
module bus_out_seq #(
    parameter int NUM_CH = 2,
    parameter int STAT_W = 3,
    parameter int LVL_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              grant,
    input  logic [NUM_CH-1:0] chan_req,
    input  logic [STAT_W-1:0] stat_in,
    input  logic              rst_out_req,
    input  logic [LVL_W-1:0]  irq_lvl_n,
    input  logic [LVL_W-1:0]  irq_mask,
    output logic [NUM_CH-1:0] chan_n,
    output logic [NUM_CH-1:0] chan_oe,
    output logic [STAT_W-1:0] stat_o,
    output logic              rst_out_n,
    output logic [LVL_W-1:0]  irq_lvl_o,
    output logic              irq_pend_n
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        bus_out_chan u_ch (
            .clk    (clk),
            .rst    (rst),
            .clk_en (clk_en),
            .grant  (grant),
            .req    (chan_req[g]),
            .pin_n  (chan_n[g]),
            .pin_oe (chan_oe[g])
        );
    end

    bus_out_status #(
        .STAT_W (STAT_W),
        .LVL_W  (LVL_W)
    ) u_stat (
        .clk         (clk),
        .rst         (rst),
        .stat_in     (stat_in),
        .rst_out_req (rst_out_req),
        .irq_lvl_n   (irq_lvl_n),
        .irq_mask    (irq_mask),
        .stat_o      (stat_o),
        .rst_out_n   (rst_out_n),
        .irq_lvl_o   (irq_lvl_o),
        .irq_pend_n  (irq_pend_n)
    );

endmodule

// File: tb/sim_bus_out_seq.sv
`timescale 1ns/1ps
module sim_bus_out_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clk_en = 1'b0;
    logic       grant = 1'b0;
    logic [1:0] chan_req = 2'b00;
    logic [2:0] stat_in = 3'd0;
    logic       rst_out_req = 1'b0;
    logic [2:0] irq_lvl_n = 3'b111;
    logic [2:0] irq_mask = 3'd0;
    logic [1:0] chan_n, chan_oe;
    logic [2:0] stat_o, irq_lvl_o;
    logic       rst_out_n, irq_pend_n;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    bus_out_seq u0 (
        .clk(clk), .rst(rst), .clk_en(clk_en), .grant(grant),
        .chan_req(chan_req), .stat_in(stat_in), .rst_out_req(rst_out_req),
        .irq_lvl_n(irq_lvl_n), .irq_mask(irq_mask),
        .chan_n(chan_n), .chan_oe(chan_oe), .stat_o(stat_o),
        .rst_out_n(rst_out_n), .irq_lvl_o(irq_lvl_o), .irq_pend_n(irq_pend_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic en);
        @(negedge clk);
        clk_en = en;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        tick(1'b1);
        tick(1'b1);
        check("R1 chan_n", {6'd0, chan_n}, 8'h03);
        check("R1 chan_oe", {6'd0, chan_oe}, 8'h00);
        check("R1 status", {stat_o, rst_out_n, irq_lvl_o, irq_pend_n}, 8'b000_1_000_1);
        rst = 1'b0;
    endtask

    task automatic t_acquire;
        grant = 1'b1; chan_req = 2'b11;
        tick(1'b0);
        check("R2 no drive off bus edge", {6'd0, chan_oe}, 8'h00);
        tick(1'b1);
        check("R2 oe on bus edge", {6'd0, chan_oe}, 8'h03);
        check("R2 level on bus edge", {6'd0, chan_n}, 8'h00);
    endtask

    task automatic t_hold;
        chan_req = 2'b00;
        tick(1'b0);
        check("R3 hold between edges", {6'd0, chan_n}, 8'h00);
        tick(1'b1);
        check("R3 update on bus edge", {6'd0, chan_n}, 8'h03);
    endtask

    task automatic t_negate;
        chan_req = 2'b11;
        tick(1'b1);
        check("R3 asserted", {6'd0, chan_n}, 8'h00);
        grant = 1'b0;
        tick(1'b0);
        check("R4 negate level", {6'd0, chan_n}, 8'h03);
        check("R4 negate still driven", {6'd0, chan_oe}, 8'h03);
        tick(1'b0);
        check("R5 released after one clock", {6'd0, chan_oe}, 8'h00);
        check("R5 released level", {6'd0, chan_n}, 8'h03);
    endtask

    task automatic t_idle_release;
        grant = 1'b1; chan_req = 2'b00;
        tick(1'b1);
        check("R6 driving idle", {6'd0, chan_oe}, 8'h03);
        grant = 1'b0;
        tick(1'b0);
        check("R6 no release off edge", {6'd0, chan_oe}, 8'h03);
        check("R6 level stays high", {6'd0, chan_n}, 8'h03);
        tick(1'b1);
        check("R6 release on bus edge", {6'd0, chan_oe}, 8'h00);
    endtask

    task automatic t_regrant;
        grant = 1'b1; chan_req = 2'b10;
        tick(1'b0);
        check("R7 no early drive", {6'd0, chan_oe}, 8'h00);
        tick(1'b1);
        check("R7 resume on bus edge", {6'd0, chan_oe}, 8'h03);
        check("R7 resumed level", {6'd0, chan_n}, 8'h01);
    endtask

    task automatic t_indep;
        chan_req = 2'b01;
        tick(1'b1);
        check("R11 mixed levels", {6'd0, chan_n}, 8'h02);
        grant = 1'b0;
        tick(1'b0);
        check("R11 both still driven", {6'd0, chan_oe}, 8'h03);
        tick(1'b0);
        check("R11 ch0 released ch1 waiting", {6'd0, chan_oe}, 8'h02);
        tick(1'b1);
        check("R11 ch1 released on edge", {6'd0, chan_oe}, 8'h00);
    endtask

    task automatic t_status;
        stat_in = 3'd5;
        tick(1'b0);
        check("R8 status off edge", {5'd0, stat_o}, 8'h05);
        stat_in = 3'd2;
        tick(1'b1);
        check("R8 status on edge", {5'd0, stat_o}, 8'h02);
        rst_out_req = 1'b1;
        tick(1'b0);
        check("R9 reset out asserted", {7'd0, rst_out_n}, 8'h00);
        rst_out_req = 1'b0;
        tick(1'b0);
        check("R9 reset out negated", {7'd0, rst_out_n}, 8'h01);
    endtask

    task automatic t_irq;
        irq_mask = 3'd2;
        irq_lvl_n = ~3'd3;
        tick(1'b0);
        check("R10 level above mask", {irq_lvl_o, 4'd0, irq_pend_n}, {3'd3, 4'd0, 1'b0});
        irq_lvl_n = ~3'd2;
        tick(1'b0);
        check("R10 level equal mask", {irq_lvl_o, 4'd0, irq_pend_n}, {3'd2, 4'd0, 1'b1});
        irq_mask = 3'd0; irq_lvl_n = ~3'd7;
        tick(1'b0);
        check("R10 top level", {irq_lvl_o, 4'd0, irq_pend_n}, {3'd7, 4'd0, 1'b0});
    endtask

    initial begin
        t_reset();
        t_acquire();
        t_hold();
        t_negate();
        t_idle_release();
        t_regrant();
        t_indep();
        t_status();
        t_irq();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #20000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule